// File: doc/BRIEF.md
# Flash Byte-Program and Chip-Erase Engine

This block is the internal write engine of a byte-wide non-volatile memory, written as a synchronous module. A command decoder in front of it hands over decoded requests: program one byte, erase the whole array, or lock the boot region. The engine then runs each operation for a fixed number of clock cycles using its own counter and commits the result to a behavioural cell array when the count ends. No clock other than the system clock is needed.

Programming can only clear bits. The new byte is the old byte ANDed with the loaded data. Erase returns cells to all ones. A lock bit, once set, makes the boot region at the bottom of the address space immune to both program and erase, and nothing clears it.

While an operation runs, reads return a status byte instead of array contents. The status byte carries an inverted copy of the loaded bit 7 and a bit 6 that flips on every read. Software polls it to learn when the operation has finished. Sizes and durations are parameters: the array holds 2**ADDR_W bytes, the boot region holds the lowest 2**BOOT_W bytes, and the durations are clock counts.

Top module: `flash_wr_engine`

## Requirements
- R1: After reset, every array byte reads 0xFF, `busy` is 0 and `locked` is 0.
- R2: A program request (`req_op` = 2'b01) stores old AND `req_data` at `req_addr`, so bits already at 0 never return to 1.
- R3: `busy` rises on the clock edge that accepts a request. It stays high for exactly PROG_CYCLES cycles for program and lock, and for exactly ERASE_CYCLES cycles for erase (`req_op` = 2'b10).
- R4: A request presented while `busy` is high is ignored: it changes no byte, the lock, or the running operation's length. `req_op` = 2'b00 is never accepted.
- R5: With the lock clear, a chip erase sets every byte, boot region included, to 0xFF.
- R6: A lock request (`req_op` = 2'b11) sets `locked` when its timed cycle ends. `locked` then stays 1 and no request clears it.
- R7: While `locked` is 1, a program to an address below 2**BOOT_W leaves that byte unchanged, and chip erase leaves every boot byte unchanged while still erasing the rest of the array.
- R8: A read while `busy` is high returns a status byte. Bit 7 is the complement of the loaded data's bit 7 for a program, and 0 for erase or lock. Bits 5..0 are 0.
- R9: Status bit 6 is 0 on the first read after a request is accepted and inverts on each later read while `busy` stays high. Reads while idle return array data.
- R10: `rd_data` updates on the clock edge that samples `rd_en` high and otherwise holds its value. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe from the command decoder |
| req_op | input | 2 | 01 program, 10 chip erase, 11 boot lock, 00 none |
| req_addr | input | ADDR_W | Byte address for program |
| req_data | input | 8 | Data for program |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data or status byte |
| busy | output | 1 | Operation in progress |
| locked | output | 1 | Boot region protection active |

## Verification
`busy` is first seen high in the cycle after the accepting edge. The bench counts the falling-edge samples in which it remains high and compares that count with the duration. A read result appears one edge after `rd_en` is sampled, so the bench drives at one falling edge and samples `rd_data` at the next. A committed byte is visible to any read issued once `busy` is low. Status polling holds `rd_en` across consecutive cycles and expects bit 6 to alternate from 0. The sweeps program, erase and read every address of the small default array, and the expected values come from the AND, all-ones and boot-range rules.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_LOCK  = 2'b11
    } op_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/fe_cycle_timer.sv
module fe_cycle_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = load_val;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.busy && (st_q.cnt == '0);

    // R3
    end_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(st_q.cnt) == '0);
endmodule

// File: rtl/fe_cell_array.sv
module fe_cell_array
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BOOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_go,
    input  logic              era_go,
    input  logic              locked,
    input  logic [ADDR_W-1:0] wa,
    input  logic [7:0]        wd,
    input  logic [ADDR_W-1:0] ra,
    output logic [7:0]        rword
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int BOOT_SZ = 1 << BOOT_W;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];
    logic       wa_in_boot;

    assign wa_in_boot = (int'(wa) < BOOT_SZ);

    always_comb begin
        mem_d = mem_q;
        if (pgm_go && !(locked && wa_in_boot))
            mem_d[wa] = mem_q[wa] & wd;
        if (era_go) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!(locked && i < BOOT_SZ)) mem_d[i] = ERASED_BYTE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED_BYTE;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rword = mem_q[ra];

    // R7
    boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_go && locked && wa_in_boot) |=> mem_q[wa] == $past(mem_q[wa]));

    // R5
    erase_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        era_go |=> mem_q[DEPTH-1] == ERASED_BYTE);
endmodule

// File: rtl/fe_read_path.sv
module fe_read_path (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rd_en,
    input  logic       busy,
    input  logic       is_prog,
    input  logic       ld_b7,
    input  logic [7:0] arr_word,
    output logic [7:0] rd_data
);
    typedef struct packed {
        logic       tog;
        logic [7:0] dout;
    } rp_t;

    rp_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            if (busy) st_d.dout = {(is_prog ? ~ld_b7 : 1'b0), st_q.tog, 6'b0};
            else      st_d.dout = arr_word;
        end
        if (start)              st_d.tog = 1'b0;
        else if (rd_en && busy) st_d.tog = ~st_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.dout;

    // R8
    status_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> rd_data[5:0] == 6'b0);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/flash_wr_engine.sv
module flash_wr_engine
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int BOOT_W       = 5,
    parameter int PROG_CYCLES  = 30,
    parameter int ERASE_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              locked
);
    localparam int MAXC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              locked;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic             accept, done, tmr_busy;
    logic [CNT_W-1:0] load_val;
    logic [7:0]       arr_word;
    op_e              req_kind;

    assign req_kind = op_e'(req_op);
    assign accept   = req_valid && (req_kind != OP_NONE) && !tmr_busy;
    assign load_val = (req_kind == OP_ERASE) ? CNT_W'(ERASE_CYCLES - 1)
                                             : CNT_W'(PROG_CYCLES - 1);

    always_comb begin
        ctl_d = ctl_q;
        if (accept) begin
            ctl_d.op   = req_kind;
            ctl_d.addr = req_addr;
            ctl_d.data = req_data;
        end
        if (done && ctl_q.op == OP_LOCK) ctl_d.locked = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{op: OP_NONE, addr: '0, data: '0, locked: 1'b0};
        else        ctl_q <= ctl_d;
    end

    fe_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .load_val (load_val),
        .busy     (tmr_busy),
        .done     (done)
    );

    fe_cell_array #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .pgm_go (done && ctl_q.op == OP_PROG),
        .era_go (done && ctl_q.op == OP_ERASE),
        .locked (ctl_q.locked),
        .wa     (ctl_q.addr),
        .wd     (ctl_q.data),
        .ra     (rd_addr),
        .rword  (arr_word)
    );

    fe_read_path u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .rd_en    (rd_en),
        .busy     (tmr_busy),
        .is_prog  (ctl_q.op == OP_PROG),
        .ld_b7    (ctl_q.data[7]),
        .arr_word (arr_word),
        .rd_data  (rd_data)
    );

    assign busy   = tmr_busy;
    assign locked = ctl_q.locked;

    // R6
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.locked |=> ctl_q.locked);

    // R4
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_busy && req_valid) |=> $stable(ctl_q.addr) && $stable(ctl_q.op));
endmodule

// File: tb/sim_flash_wr_engine.sv
`timescale 1ns/1ps
module sim_flash_wr_engine;
    localparam int AW = 8;
    localparam int BW = 5;
    localparam int PC = 30;
    localparam int EC = 1000;
    localparam int DEPTH = 1 << AW;
    localparam int BOOT = 1 << BW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic busy, locked;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    flash_wr_engine #(.ADDR_W(AW), .BOOT_W(BW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .locked(locked)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_a(input int a);
        return 8'((a * 37 + 11) & 8'hFF);
    endfunction
    function automatic logic [7:0] pat_b(input int a);
        return 8'((a ^ 8'h96) | 8'h21);
    endfunction
    function automatic logic [7:0] pat_c(input int a);
        return 8'(a ^ 8'hC3);
    endfunction

    task automatic issue(input logic [1:0] op, input int a, input int d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_data = 8'(d);
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'b00;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 5000) begin n++; @(negedge clk); end
    endtask

    task automatic run_op(input logic [1:0] op, input int a, input int d,
                          input int dur, input string tag);
        int n;
        issue(op, a, d);
        wait_idle(n);
        chk(tag, n, dur);
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        v = rd_data;
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R10 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 locked", int'(locked), 0);
        chk("R10 rd_data reset", int'(rd_data), 0);
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, v);
            chk("R1 erased", int'(v), 8'hFF);
        end

        // R8 / R9 status polling during a program
        issue(2'b01, 7, 8'h35);
        rd_en = 1'b1; rd_addr = AW'(7);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R8 R9 prog status", int'(rd_data), {1'b1, 1'(i % 2), 6'b0});
        end
        rd_en = 1'b0;
        wait_idle(n);
        rd(7, v);
        chk("R9 idle read after prog", int'(v), 8'h35);

        // R10 hold while rd_en low
        repeat (3) @(negedge clk);
        chk("R10 hold", int'(rd_data), 8'h35);

        // R2 / R3 program sweep, then AND sweep
        for (int a = 0; a < DEPTH; a++) run_op(2'b01, a, pat_a(a), PC, "R3 prog duration");
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, v);
            chk("R2 program", int'(v), int'(pat_a(a) & (a == 7 ? 8'h35 : 8'hFF)));
        end
        for (int a = 0; a < DEPTH; a++) run_op(2'b01, a, pat_b(a), PC, "R3 prog duration");
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, v);
            chk("R2 and", int'(v), int'(pat_a(a) & pat_b(a) & (a == 7 ? 8'h35 : 8'hFF)));
        end

        // R4 requests while busy ignored, op 00 ignored
        issue(2'b01, 40, 8'h00);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b01; req_addr = AW'(41); req_data = 8'h00;
        @(negedge clk);
        req_op = 2'b10;
        @(negedge clk);
        req_op = 2'b11;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'b00;
        wait_idle(n);
        chk("R4 duration unchanged", n + 4, PC);
        repeat (2) @(negedge clk);
        chk("R4 no restart", int'(busy), 0);
        chk("R4 lock untouched", int'(locked), 0);
        rd(41, v);
        chk("R4 byte untouched", int'(v), int'(pat_a(41) & pat_b(41)));
        rd(40, v);
        chk("R4 first op done", int'(v), 0);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 op none", int'(busy), 0);

        // R5 / R8 erase with status poll
        issue(2'b10, 0, 8'h80);
        rd_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 R9 erase status", int'(rd_data), {1'b0, 1'(i % 2), 6'b0});
        end
        rd_en = 1'b0;
        wait_idle(n);
        chk("R3 erase duration", n + 3, EC);
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, v);
            chk("R5 erase", int'(v), 8'hFF);
        end

        // R6 / R7 lock and protection
        for (int a = 0; a < BOOT; a++) run_op(2'b01, a, pat_c(a), PC, "R3 prog duration");
        run_op(2'b11, 0, 0, PC, "R3 lock duration");
        chk("R6 locked set", int'(locked), 1);
        for (int a = 0; a < DEPTH; a++) run_op(2'b01, a, 8'h00, PC, "R3 prog duration");
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, v);
            chk("R7 locked program", int'(v), (a < BOOT) ? int'(pat_c(a)) : 0);
        end
        run_op(2'b10, 0, 0, EC, "R3 erase duration");
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, v);
            chk("R7 locked erase", int'(v), (a < BOOT) ? int'(pat_c(a)) : 8'hFF);
        end
        run_op(2'b11, 0, 0, PC, "R3 lock duration");
        chk("R6 lock sticky", int'(locked), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule